// File: doc/BRIEF.md
# I2C Master Byte Receiver

This engine reads one data byte from an I2C slave once the address phase is over and the master is holding SCL low. The host raises a receive request while the engine is idle. The engine then runs a half-period counter. On each counter rollover it toggles SCL, and it shifts in eight SDA bits, most significant bit first. When the byte is complete, the engine parks SCL low and places the byte in a read buffer. It then raises the buffer-full and interrupt flags.

A byte that completes while the previous byte is still unread does not replace it. Instead the overflow flag is raised. A host write attempt during a receive raises a write-collision flag and has no effect on the buffer. Once a byte is done, the host can run a separate acknowledge sequence. This sequence drives the ninth bit with a chosen level and clocks it out with one SCL pulse.

The controller has five states:
- `ST_IDLE`: SCL held low, SDA released.
- `ST_RX_LOW` and `ST_RX_HIGH`: the two halves of each receive bit.
- `ST_ACK_LOW` and `ST_ACK_HIGH`: the two halves of the acknowledge bit.

The transitions are:
- accept-receive: `ST_IDLE` to `ST_RX_LOW`.
- rise: `ST_RX_LOW` to `ST_RX_HIGH`, on rollover.
- fall-next-bit: `ST_RX_HIGH` to `ST_RX_LOW`, on rollover before the last bit.
- byte-complete: `ST_RX_HIGH` to `ST_IDLE`, on rollover at the last bit.
- accept-ack: `ST_IDLE` to `ST_ACK_LOW`.
- ack-rise: `ST_ACK_LOW` to `ST_ACK_HIGH`, on rollover.
- ack-complete: `ST_ACK_HIGH` to `ST_IDLE`, on rollover.

Top module: `i2c_master_rx_byte`

## Requirements
- R1: After reset, `rd_data` is 0 and all flags are 0. The flags are `buf_full`, `irq_flag`, `ovf_flag`, `wcol_flag`, `rx_enable` and `ack_enable`. `scl_pull_low` is 1 (SCL held low) and `sda_pull_low` is 0 (SDA released).
- R2: A `rx_go` pulse in idle sets `rx_enable` on the next edge. SCL then stays low for BAUD_DIV cycles and high for BAUD_DIV cycles, alternating, and SDA stays released throughout the receive.
- R3: SDA is sampled on the clock edge that ends each high phase, MSB first. On the edge that ends the eighth high phase, `rx_enable` clears, SCL is held low, the byte appears on `rd_data`, and `buf_full` and `irq_flag` are set. A receive therefore lasts 16*BAUD_DIV cycles.
- R4: A `buf_rd` pulse clears `buf_full`.
- R5: If a byte completes while `buf_full` is set and no `buf_rd` arrives in that same cycle, `ovf_flag` is set. `rd_data` keeps the old byte and the new byte is dropped. `ovf_flag` stays set until `ovf_clr`.
- R6: A `buf_wr` pulse during a receive sets `wcol_flag` and leaves the buffer unchanged, so `rd_data` later shows only the received byte. A `buf_wr` pulse in idle does not set `wcol_flag`.
- R7: A `rx_go` pulse while a receive or an acknowledge sequence is running is ignored: the receive timing and data are unchanged, and no new receive starts.
- R8: An `ack_go` pulse in idle sets `ack_enable` and drives SDA to `ack_level` (0 drives low for ACK, 1 releases for NACK). SCL stays low for BAUD_DIV cycles, is released for BAUD_DIV cycles, and is then held low again. At that point `ack_enable` clears and `irq_flag` is set.
- R9: An `ack_go` pulse during a receive is ignored, and `rx_go` wins if both arrive together in idle.
- R10: `irq_clr` clears `irq_flag` and `wcol_clr` clears `wcol_flag`. If a flag is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_go | input | 1 | Request a byte receive (honoured in idle only) |
| ack_go | input | 1 | Request the acknowledge bit (honoured in idle only) |
| ack_level | input | 1 | Level for the acknowledge bit: 0 = ACK, 1 = NACK |
| buf_wr | input | 1 | Host write attempt on the buffer |
| buf_rd | input | 1 | Host read of the buffer; clears buffer-full |
| irq_clr | input | 1 | Clear the interrupt flag |
| ovf_clr | input | 1 | Clear the overflow flag |
| wcol_clr | input | 1 | Clear the write-collision flag |
| sda_in | input | 1 | Sampled SDA line level |
| scl_pull_low | output | 1 | 1 = drive SCL low, 0 = release |
| sda_pull_low | output | 1 | 1 = drive SDA low, 0 = release |
| rd_data | output | DATA_W | Read buffer contents |
| buf_full | output | 1 | Unread byte in the buffer |
| irq_flag | output | 1 | Byte or acknowledge sequence finished |
| ovf_flag | output | 1 | A byte was dropped because the buffer was unread |
| wcol_flag | output | 1 | Write attempted during a receive |
| rx_enable | output | 1 | Receive in progress |
| ack_enable | output | 1 | Acknowledge sequence in progress |

## Verification
The assertions check several properties on every cycle:
- SDA stays released whenever a receive is running.
- Each end of receive or acknowledge leaves SCL low with the completion flags set.
- A rising overflow or write-collision flag never coincides with a change of the buffer.
- A receive request made during an acknowledge never starts one, and counter rollovers are never back to back.

Other behaviours need whole transactions and only the bench scenarios can show them. These are the byte value assembled MSB first from a slave model, the exact SCL phase lengths, the old byte surviving a skipped read, and the ACK or NACK level seen on SDA during the ninth clock high phase.

// File: rtl/i2crx_pkg.sv
package i2crx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RX_LOW   = 3'd1,
        ST_RX_HIGH  = 3'd2,
        ST_ACK_LOW  = 3'd3,
        ST_ACK_HIGH = 3'd4
    } rx_state_e;

endpackage

// File: rtl/i2crx_baud.sv
// Half-period counter: emits a one-cycle rollover every BAUD_DIV cycles while run is high.
module i2crx_baud #(
    parameter int BAUD_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (BAUD_DIV > 2) ? $clog2(BAUD_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BAUD_DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: every SCL phase lasts at least two cycles, so rollovers never touch
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/i2crx_shift.sv
// Receive shift register with bit counter; next_byte includes the bit being sampled.
module i2crx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic              sda,
    output logic [DATA_W-1:0] next_byte,
    output logic              last_bit
);
    localparam int CW = $clog2(DATA_W);
    localparam logic [CW-1:0] LAST_IDX = CW'(DATA_W - 1);

    logic [DATA_W-1:0] sh_q;
    logic [CW-1:0]     idx_q;

    assign next_byte = {sh_q[DATA_W-2:0], sda};
    assign last_bit  = (idx_q == LAST_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (clear) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (sample) begin
            sh_q  <= next_byte;
            idx_q <= last_bit ? '0 : idx_q + 1'b1;
        end
    end

endmodule

// File: rtl/i2c_master_rx_byte.sv
module i2c_master_rx_byte
    import i2crx_pkg::*;
#(
    parameter int BAUD_DIV = 4,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_go,
    input  logic              ack_go,
    input  logic              ack_level,
    input  logic              buf_wr,
    input  logic              buf_rd,
    input  logic              irq_clr,
    input  logic              ovf_clr,
    input  logic              wcol_clr,
    input  logic              sda_in,
    output logic              scl_pull_low,
    output logic              sda_pull_low,
    output logic [DATA_W-1:0] rd_data,
    output logic              buf_full,
    output logic              irq_flag,
    output logic              ovf_flag,
    output logic              wcol_flag,
    output logic              rx_enable,
    output logic              ack_enable
);
    rx_state_e         state_q, state_d;
    logic              tick;
    logic              idle;
    logic              rx_accept, ack_accept;
    logic              sample, byte_done, ack_done;
    logic              last_bit;
    logic [DATA_W-1:0] byte_next;
    logic [DATA_W-1:0] buf_q;
    logic              ack_val_q;
    logic              buf_full_q, irq_q, ovf_q, wcol_q;

    assign idle       = (state_q == ST_IDLE);
    assign rx_accept  = idle && rx_go;
    assign ack_accept = idle && ack_go && !rx_go;
    assign sample     = (state_q == ST_RX_HIGH) && tick;
    assign byte_done  = sample && last_bit;
    assign ack_done   = (state_q == ST_ACK_HIGH) && tick;

    i2crx_baud #(.BAUD_DIV(BAUD_DIV)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (!idle),
        .tick (tick)
    );

    i2crx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (rx_accept),
        .sample   (sample),
        .sda      (sda_in),
        .next_byte(byte_next),
        .last_bit (last_bit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rx_accept)       state_d = ST_RX_LOW;
                else if (ack_accept) state_d = ST_ACK_LOW;
            end
            ST_RX_LOW:   if (tick) state_d = ST_RX_HIGH;
            ST_RX_HIGH:  if (tick) state_d = last_bit ? ST_IDLE : ST_RX_LOW;
            ST_ACK_LOW:  if (tick) state_d = ST_ACK_HIGH;
            ST_ACK_HIGH: if (tick) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Line and status outputs decoded from the state
    always_comb begin
        scl_pull_low = 1'b1;
        sda_pull_low = 1'b0;
        rx_enable    = 1'b0;
        ack_enable   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RX_LOW:   rx_enable = 1'b1;
            ST_RX_HIGH: begin
                rx_enable    = 1'b1;
                scl_pull_low = 1'b0;
            end
            ST_ACK_LOW: begin
                ack_enable   = 1'b1;
                sda_pull_low = !ack_val_q;
            end
            ST_ACK_HIGH: begin
                ack_enable   = 1'b1;
                scl_pull_low = 1'b0;
                sda_pull_low = !ack_val_q;
            end
            default: ;
        endcase
    end

    // Buffer and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q      <= '0;
            buf_full_q <= 1'b0;
            irq_q      <= 1'b0;
            ovf_q      <= 1'b0;
            wcol_q     <= 1'b0;
            ack_val_q  <= 1'b1;
        end else begin
            if (ack_accept) ack_val_q <= ack_level;

            if (byte_done && (!buf_full_q || buf_rd)) buf_q <= byte_next;

            if (byte_done)   buf_full_q <= 1'b1;
            else if (buf_rd) buf_full_q <= 1'b0;

            if (byte_done && buf_full_q && !buf_rd) ovf_q <= 1'b1;
            else if (ovf_clr)                       ovf_q <= 1'b0;

            if (byte_done || ack_done) irq_q <= 1'b1;
            else if (irq_clr)          irq_q <= 1'b0;

            if (buf_wr && rx_enable) wcol_q <= 1'b1;
            else if (wcol_clr)       wcol_q <= 1'b0;
        end
    end

    assign rd_data   = buf_q;
    assign buf_full  = buf_full_q;
    assign irq_flag  = irq_q;
    assign ovf_flag  = ovf_q;
    assign wcol_flag = wcol_q;

    // R2: SDA is never driven by the master while bits are shifting in
    assert_sda_free_rx_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_enable |-> !sda_pull_low);

    // R3: the end of a receive parks SCL low with the buffer full and interrupt raised
    assert_done_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_enable) |-> (scl_pull_low && buf_full && irq_flag));

    // R5: the cycle overflow rises, the buffered byte is left alone
    assert_ovf_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $stable(rd_data));

    // R6: a collision alone never changes the buffer
    assert_wcol_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wcol_flag) && !$fell(rx_enable)) |-> $stable(rd_data));

    // R7: a receive request during the acknowledge sequence never starts a receive
    assert_rx_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_enable && rx_go) |=> !rx_enable);

    // R8: the acknowledge sequence ends with SCL low and the interrupt raised
    assert_ack_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_enable) |-> (scl_pull_low && irq_flag && !rx_enable));

endmodule

// File: tb/i2c_master_rx_byte_tb.sv
module i2c_master_rx_byte_tb;
    localparam int BAUD_DIV = 4;
    localparam int DATA_W   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_go = 0, ack_go = 0, ack_level = 0, buf_wr = 0, buf_rd = 0;
    logic irq_clr = 0, ovf_clr = 0, wcol_clr = 0;
    logic slave_sda = 1'b1;
    logic scl_pull_low, sda_pull_low;
    logic [DATA_W-1:0] rd_data;
    logic buf_full, irq_flag, ovf_flag, wcol_flag, rx_enable, ack_enable;
    logic sda_bus, scl_bus;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int low_cnt, high_cnt, rx_cycles;

    assign sda_bus = sda_pull_low ? 1'b0 : slave_sda;
    assign scl_bus = !scl_pull_low;

    i2c_master_rx_byte #(.BAUD_DIV(BAUD_DIV), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_go(rx_go), .ack_go(ack_go), .ack_level(ack_level),
        .buf_wr(buf_wr), .buf_rd(buf_rd), .irq_clr(irq_clr), .ovf_clr(ovf_clr),
        .wcol_clr(wcol_clr), .sda_in(sda_bus), .scl_pull_low(scl_pull_low),
        .sda_pull_low(sda_pull_low), .rd_data(rd_data), .buf_full(buf_full),
        .irq_flag(irq_flag), .ovf_flag(ovf_flag), .wcol_flag(wcol_flag),
        .rx_enable(rx_enable), .ack_enable(ack_enable)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    always @(negedge clk) if (rx_enable) rx_cycles <= rx_cycles + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    // Receive one byte from the slave model; inject: 0 none, 1 rx_go, 2 buf_wr, 3 ack_go at bit 3
    task automatic receive_byte(input logic [7:0] b, input int inject);
        slave_sda = b[7];
        rx_cycles = 0;
        @(negedge clk);
        rx_go = 1'b1;
        @(negedge clk);
        rx_go = 1'b0;
        low_cnt = 0;
        while (scl_bus == 1'b0) begin low_cnt++; @(negedge clk); end
        high_cnt = 0;
        while (scl_bus == 1'b1) begin high_cnt++; @(negedge clk); end
        slave_sda = b[6];
        for (int i = 1; i < 8; i++) begin
            if (i == 3 && inject == 1) pulse(rx_go);
            if (i == 3 && inject == 2) pulse(buf_wr);
            if (i == 3 && inject == 3) pulse(ack_go);
            while (scl_bus == 1'b0) @(negedge clk);
            while (scl_bus == 1'b1) @(negedge clk);
            slave_sda = (i < 7) ? b[6-i] : 1'b1;
        end
    endtask

    task automatic t_reset;
        chk("R1 rd_data", rd_data, 0);
        chk("R1 flags", {buf_full, irq_flag, ovf_flag, wcol_flag, rx_enable, ack_enable}, 0);
        chk("R1 scl held low", scl_pull_low, 1);
        chk("R1 sda released", sda_pull_low, 0);
    endtask

    task automatic t_basic_receive;
        receive_byte(8'hA5, 0);
        chk("R2 scl low phase", low_cnt, BAUD_DIV);
        chk("R2 scl high phase", high_cnt, BAUD_DIV);
        chk("R3 byte value", rd_data, 8'hA5);
        chk("R3 buf_full irq", {buf_full, irq_flag}, 2'b11);
        chk("R3 rx_enable cleared", rx_enable, 0);
        chk("R3 scl parked low", scl_pull_low, 1);
        chk("R3 receive length", rx_cycles, 16 * BAUD_DIV);
        pulse(buf_rd);
        chk("R4 buf_full cleared", buf_full, 0);
        pulse(irq_clr);
        chk("R10 irq cleared", irq_flag, 0);
    endtask

    task automatic t_overflow;
        receive_byte(8'h3C, 0);
        chk("R3 second pattern", rd_data, 8'h3C);
        receive_byte(8'hF0, 0);
        chk("R5 ovf set", ovf_flag, 1);
        chk("R5 old byte kept", rd_data, 8'h3C);
        chk("R5 buf_full stays", buf_full, 1);
        repeat (3) @(negedge clk);
        chk("R5 ovf sticky", ovf_flag, 1);
        pulse(ovf_clr);
        chk("R5 ovf cleared", ovf_flag, 0);
        pulse(buf_rd);
        pulse(irq_clr);
        receive_byte(8'h0F, 0);
        chk("R5 no ovf after read", ovf_flag, 0);
        chk("R3 pattern 0F", rd_data, 8'h0F);
        pulse(buf_rd);
        pulse(irq_clr);
    endtask

    task automatic t_collision;
        receive_byte(8'h96, 2);
        chk("R6 wcol set", wcol_flag, 1);
        chk("R6 buffer holds received byte", rd_data, 8'h96);
        pulse(wcol_clr);
        chk("R10 wcol cleared", wcol_flag, 0);
        pulse(buf_wr);
        chk("R6 idle write no wcol", wcol_flag, 0);
        chk("R6 idle write buffer unchanged", rd_data, 8'h96);
        pulse(buf_rd);
        pulse(irq_clr);
    endtask

    task automatic t_rx_ignored;
        receive_byte(8'h5A, 1);
        chk("R7 data intact", rd_data, 8'h5A);
        chk("R7 length intact", rx_cycles, 16 * BAUD_DIV);
        repeat (2) @(negedge clk);
        chk("R7 no restart", rx_enable, 0);
        pulse(buf_rd);
        pulse(irq_clr);
    endtask

    task automatic t_ack_ignored;
        receive_byte(8'hC3, 3);
        chk("R9 data intact", rd_data, 8'hC3);
        repeat (2 * BAUD_DIV) begin
            @(negedge clk);
            checks = checks + 1;
            if (ack_enable !== 1'b0 || scl_pull_low !== 1'b1) begin
                errors = errors + 1;
                $display("FAIL R9: actual ack_enable=%0b scl_pull_low=%0b expected 0/1",
                         ack_enable, scl_pull_low);
            end
        end
        // simultaneous requests: receive wins
        slave_sda = 1'b1;
        rx_go = 1'b1; ack_go = 1'b1;
        @(negedge clk);
        rx_go = 1'b0; ack_go = 1'b0;
        chk("R9 rx wins", {rx_enable, ack_enable}, 2'b10);
        while (rx_enable) @(negedge clk);
        pulse(buf_rd);
        pulse(irq_clr);
    endtask

    task automatic t_ack(input logic lvl);
        ack_level = lvl;
        pulse(ack_go);
        chk("R8 ack_enable set", ack_enable, 1);
        chk("R8 sda level in low phase", sda_bus, lvl);
        chk("R8 scl low first", scl_pull_low, 1);
        while (scl_bus == 1'b0) @(negedge clk);
        high_cnt = 0;
        while (scl_bus == 1'b1) begin
            if (high_cnt == 1) begin
                chk("R8 sda level in ninth clock", sda_bus, lvl);
                pulse(rx_go); // R7: ignored during acknowledge
                high_cnt++;
            end
            high_cnt++;
            @(negedge clk);
        end
        chk("R8 ack high phase", high_cnt, BAUD_DIV);
        chk("R8 ack_enable cleared", ack_enable, 0);
        chk("R8 irq set", irq_flag, 1);
        chk("R7 no receive after ack", rx_enable, 0);
        pulse(irq_clr);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_basic_receive();
        t_overflow();
        t_collision();
        t_rx_ignored();
        t_ack_ignored();
        t_ack(1'b0);
        t_ack(1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule